// File: doc/BRIEF.md
# Asynchronous Debug Serial Receiver

This block takes one asynchronous serial line and turns each 8-bit character on it into a parallel byte. A 16-bit divisor sets the rate of an oversampling tick. The tick runs at sixteen times the baud rate. The line first passes through a two-flop synchronizer. After that a glitch filter rejects short low pulses, so that only real start bits begin a character. Each data bit and the stop bit are then sampled at the middle of their bit cells.

Software controls the receiver with three single-cycle command pulses:
- **Enable** starts the hunt for a start bit.
- **Disable** stops the receiver at once while it hunts. If a character has already begun, the receiver finishes that character first and then stops.
- **Reset** aborts everything at once.

A received byte is held in a data register with a ready flag, a framing-error flag and an overrun flag. A read-acknowledge pulse clears the ready flag.

Top module: `dbg_uart_rx`

## Requirements
- R1: After rst_n is low, the receiver is disabled and rx_ready, frame_err, overrun and rx_data are all zero. Characters on the line produce no ready until cmd_enable has been pulsed.
- R2: With divisor N ≥ 1, one oversample tick occurs every N clock cycles, and one bit period is 16·N clocks. With divisor 0 no tick occurs and nothing is received.
- R3: A start bit is accepted only after the synchronized line is low on 8 consecutive ticks (more than 7). A low pulse lasting 7 ticks or fewer is discarded, and hunting continues.
- R4: Data bit 0 is sampled 24 ticks after the first low tick of the start bit, and each later bit 16 ticks after the previous one. The 8 data bits arrive LSB first and are followed by one stop bit. At the stop-bit sample the byte is loaded into rx_data and rx_ready goes to 1.
- R5: If the stop-bit sample is low, the byte is still stored, rx_ready is set and frame_err becomes 1. A character with a high stop bit leaves frame_err at 0.
- R6: rx_ready stays at 1 until an rd_ack pulse clears it. A byte that completes while rx_ready is 1 (and not acknowledged in that cycle) replaces rx_data and sets overrun. rd_ack clears overrun.
- R7: cmd_disable during the start-bit hunt stops the receiver immediately, so a following character produces no ready.
- R8: cmd_disable after a start bit has been accepted lets that character complete and be stored. The receiver stops after its stop bit.
- R9: cmd_reset aborts any character in progress, disables the receiver and clears rx_ready, frame_err and overrun.
- R10: Command priority is cmd_reset over cmd_disable over cmd_enable. Enable and disable in the same cycle leave the receiver disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | 16 | Oversample tick period in clocks; 0 stops the tick |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cmd_enable | input | 1 | Pulse: start hunting for start bits |
| cmd_disable | input | 1 | Pulse: stop, gracefully if a character is in progress |
| cmd_reset | input | 1 | Pulse: abort and disable immediately |
| rd_ack | input | 1 | Pulse: byte has been read, clears ready and overrun |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| frame_err | output | 1 | Last byte had a low stop bit |
| overrun | output | 1 | A byte arrived while the previous one was unread |

## Verification
The bench drives low pulses of exactly 7 and exactly 8 ticks. A filter that is off by one either accepts the 7-tick glitch as a spurious 0xFF character or misses the 8-tick start entirely. Disable is pulsed both in the middle of a character and while hunting: a receiver that stops abruptly loses the byte in flight, and one that defers every disable keeps receiving afterwards. A reset in mid-character must leave no ready and no stale flags. Enable and disable in the same cycle, divisor zero, two unread bytes, and a low stop bit expose wrong priority, a free-running divider, missing overrun and a dropped framing error.

// File: rtl/dbg_uart_rx_pkg.sv
package dbg_uart_rx_pkg;
    // Receiver control states
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_RECV = 2'd2
    } rx_state_t;
endpackage

// File: rtl/dbg_uart_rx_baud.sv
// Oversample tick generator.
// Emits a one-cycle tick every DIV_W-bit divisor clocks; a divisor of zero
// holds the counter and suppresses all ticks. Assumes divisor is quasi-static.
module dbg_uart_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Count master clocks and pulse when a full divisor period has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n || divisor_i == '0) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= divisor_i - 1'b1) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R2
    no_tick_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i == '0) |=> !tick_o);
    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && divisor_i > 1) |=> (!tick_o || divisor_i <= 1));
endmodule

// File: rtl/dbg_uart_rx_sync.sv
// Two-flop synchronizer for the asynchronous serial line.
// Resets to the idle (high) level so no false start appears after reset.
module dbg_uart_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;

    // Shift the line through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_o <= 1'b1;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/dbg_uart_rx_fsm.sv
// Receive sequencer: start-bit glitch filter, mid-bit sampling, shift register
// and command handling. Emits done_o for one cycle at the stop-bit sample with
// the assembled byte and the stop-bit level. Assumes a synchronized line.
module dbg_uart_rx_fsm
    import dbg_uart_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OSR        = 16,
    parameter int GLITCH_MAX = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 line_i,
    input  logic                 enable_i,
    input  logic                 disable_i,
    input  logic                 reset_i,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 stop_o
);
    localparam int LOW_W   = $clog2(GLITCH_MAX + 1) + 1;
    localparam int FIRST   = OSR + OSR / 2 - (GLITCH_MAX + 1);
    localparam int WAIT_W  = $clog2(FIRST + 1);
    localparam int BIT_W   = $clog2(DATA_BITS + 1);

    rx_state_t              state_q;
    logic [LOW_W-1:0]       low_q;
    logic [WAIT_W-1:0]      wait_q;
    logic [BIT_W-1:0]       bit_q;
    logic [DATA_BITS-1:0]   shreg_q;
    logic                   pend_q;

    // Sequence the receiver through off, hunt and receive
    always_ff @(posedge clk) begin
        done_o <= 1'b0;
        if (!rst_n || reset_i) begin
            state_q <= ST_OFF;
            low_q   <= '0;
            wait_q  <= '0;
            bit_q   <= '0;
            pend_q  <= 1'b0;
            if (!rst_n) begin
                shreg_q <= '0;
                byte_o  <= '0;
                stop_o  <= 1'b1;
            end
        end else begin
            case (state_q)
                ST_OFF: begin
                    low_q <= '0;
                    if (enable_i && !disable_i) state_q <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (disable_i) begin
                        state_q <= ST_OFF;
                    end else if (tick_i) begin
                        if (line_i) begin
                            low_q <= '0;
                        end else if (low_q == LOW_W'(GLITCH_MAX)) begin
                            state_q <= ST_RECV;
                            low_q   <= '0;
                            wait_q  <= WAIT_W'(FIRST);
                            bit_q   <= '0;
                        end else begin
                            low_q <= low_q + 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (disable_i)     pend_q <= 1'b1;
                    else if (enable_i) pend_q <= 1'b0;
                    if (tick_i) begin
                        if (wait_q != '0) begin
                            wait_q <= wait_q - 1'b1;
                        end else begin
                            wait_q <= WAIT_W'(OSR - 1);
                            if (bit_q < BIT_W'(DATA_BITS)) begin
                                shreg_q <= {line_i, shreg_q[DATA_BITS-1:1]};
                                bit_q   <= bit_q + 1'b1;
                            end else begin
                                byte_o  <= shreg_q;
                                stop_o  <= line_i;
                                done_o  <= 1'b1;
                                pend_q  <= 1'b0;
                                state_q <= (pend_q || disable_i) ? ST_OFF : ST_HUNT;
                            end
                        end
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    // R9
    reset_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_i |=> (state_q == ST_OFF && !done_o));
    // R7
    hunt_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_i && !reset_i && state_q == ST_HUNT) |=> state_q == ST_OFF);
    // R10
    enable_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && disable_i && state_q == ST_OFF) |=> state_q == ST_OFF);
endmodule

// File: rtl/dbg_uart_rx_status.sv
// Holding register and status flags for received bytes.
// Loads on done_i, clears ready/overrun on rd_ack, clears flags on reset_i.
module dbg_uart_rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reset_i,
    input  logic                 done_i,
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic                 stop_i,
    input  logic                 ack_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 ready_o,
    output logic                 ferr_o,
    output logic                 ovr_o
);
    // Update the byte register and its flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            ready_o <= 1'b0;
            ferr_o  <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (reset_i) begin
            ready_o <= 1'b0;
            ferr_o  <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (done_i) begin
            data_o  <= byte_i;
            ready_o <= 1'b1;
            ferr_o  <= !stop_i;
            ovr_o   <= (ready_o || ovr_o) && !ack_i;
        end else if (ack_i) begin
            ready_o <= 1'b0;
            ovr_o   <= 1'b0;
        end
    end

    // R4
    ready_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(done_i));
    // R6
    overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(ready_o));
endmodule

// File: rtl/dbg_uart_rx.sv
// Top of the debug serial receiver: divider, synchronizer, sequencer, status.
// Commands are single-cycle pulses in the clk domain; rx_line is asynchronous.
module dbg_uart_rx #(
    parameter int DIV_W      = 16,
    parameter int DATA_BITS  = 8,
    parameter int OSR        = 16,
    parameter int GLITCH_MAX = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     divisor,
    input  logic                 rx_line,
    input  logic                 cmd_enable,
    input  logic                 cmd_disable,
    input  logic                 cmd_reset,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 frame_err,
    output logic                 overrun
);
    logic                 tick;
    logic                 line_s;
    logic                 done;
    logic [DATA_BITS-1:0] rx_byte;
    logic                 stop_lvl;

    dbg_uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor_i(divisor), .tick_o(tick)
    );

    dbg_uart_rx_sync u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rx_line), .sync_o(line_s)
    );

    dbg_uart_rx_fsm #(.DATA_BITS(DATA_BITS), .OSR(OSR), .GLITCH_MAX(GLITCH_MAX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line_s),
        .enable_i(cmd_enable), .disable_i(cmd_disable), .reset_i(cmd_reset),
        .done_o(done), .byte_o(rx_byte), .stop_o(stop_lvl)
    );

    dbg_uart_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk(clk), .rst_n(rst_n), .reset_i(cmd_reset), .done_i(done),
        .byte_i(rx_byte), .stop_i(stop_lvl), .ack_i(rd_ack),
        .data_o(rx_data), .ready_o(rx_ready), .ferr_o(frame_err), .ovr_o(overrun)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_ready && !frame_err && !overrun));
endmodule

// File: tb/dbg_uart_rx_test.sv
module dbg_uart_rx_test;
    localparam int DIV  = 4;
    localparam int TICK = DIV;
    localparam int BIT  = 16 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'(DIV);
    logic        rx_line = 1'b1;
    logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0, rd_ack = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_ready, frame_err, overrun;
    int          n_chk = 0, n_fail = 0;
    bit          done_flag = 1'b0;

    always #10 clk = ~clk;

    dbg_uart_rx uut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .rx_line(rx_line),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready),
        .frame_err(frame_err), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cmd_enable = 1'b1;
            1: cmd_disable = 1'b1;
            2: cmd_reset = 1'b1;
            3: rd_ack = 1'b1;
            default: begin cmd_enable = 1'b1; cmd_disable = 1'b1; end
        endcase
        @(negedge clk);
        cmd_enable = 1'b0; cmd_disable = 1'b0; cmd_reset = 1'b0; rd_ack = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rx_line = 1'b0; clks(BIT);
        for (int i = 0; i < 8; i++) begin rx_line = b[i]; clks(BIT); end
        rx_line = stop; clks(BIT);
        rx_line = 1'b1; clks(BIT);
    endtask

    task automatic test_reset_state();
        chk("R1 ready", rx_ready, 0); chk("R1 ferr", frame_err, 0);
        chk("R1 ovr", overrun, 0);    chk("R1 data", rx_data, 0);
        send(8'h5A, 1'b1);
        chk("R1 ignored before enable", rx_ready, 0);
    endtask

    task automatic test_basic();
        pulse(0); clks(8);
        send(8'hA5, 1'b1);
        chk("R4 ready", rx_ready, 1); chk("R4 data A5", rx_data, 8'hA5);
        chk("R5 ferr clear", frame_err, 0);
        pulse(3); clks(2);
        chk("R6 ack clears", rx_ready, 0);
        send(8'h01, 1'b1);
        chk("R4 lsb first", rx_data, 8'h01);
        pulse(3);
    endtask

    task automatic test_glitch();
        @(negedge clk); rx_line = 1'b0; clks(7 * TICK); rx_line = 1'b1; clks(3 * BIT);
        chk("R3 7-tick low ignored", rx_ready, 0);
        send(8'h3C, 1'b1);
        chk("R3 frame after glitch", rx_data, 8'h3C);
        pulse(3);
        @(negedge clk); rx_line = 1'b0; clks(8 * TICK); rx_line = 1'b1; clks(11 * BIT);
        chk("R3 8-tick low accepted", rx_ready, 1);
        chk("R3 8-tick low data", rx_data, 8'hFF);
        pulse(3);
    endtask

    task automatic test_ferr_overrun();
        send(8'h77, 1'b0);
        chk("R5 ferr set", frame_err, 1); chk("R5 stored", rx_data, 8'h77);
        chk("R5 ready", rx_ready, 1);
        send(8'hC3, 1'b1);
        chk("R6 overrun", overrun, 1); chk("R6 new data", rx_data, 8'hC3);
        chk("R5 ferr cleared", frame_err, 0);
        pulse(3); clks(2);
        chk("R6 ack clears ovr", overrun, 0); chk("R6 ack clears ready", rx_ready, 0);
    endtask

    task automatic test_disable();
        fork
            send(8'h96, 1'b1);
            begin clks(4 * BIT); pulse(1); end
        join
        chk("R8 graceful byte", rx_ready, 1); chk("R8 data", rx_data, 8'h96);
        pulse(3);
        send(8'h11, 1'b1);
        chk("R8 stopped after", rx_ready, 0);
        pulse(0); clks(8); pulse(1);
        send(8'h22, 1'b1);
        chk("R7 hunt disable", rx_ready, 0);
        pulse(4);
        send(8'h33, 1'b1);
        chk("R10 disable beats enable", rx_ready, 0);
    endtask

    task automatic test_abort();
        pulse(0); clks(8);
        send(8'h44, 1'b0);
        fork
            send(8'h55, 1'b1);
            begin clks(4 * BIT); pulse(2); end
        join
        chk("R9 no ready", rx_ready, 0); chk("R9 ferr clear", frame_err, 0);
        chk("R9 data kept", rx_data, 8'h44);
        send(8'h66, 1'b1);
        chk("R9 disabled", rx_ready, 0);
        pulse(0); clks(8);
        send(8'h69, 1'b1);
        chk("R9 recovers", rx_data, 8'h69);
        pulse(3);
    endtask

    task automatic test_div0();
        divisor = 16'd0; clks(4);
        send(8'h5C, 1'b1);
        chk("R2 divisor zero", rx_ready, 0);
        divisor = 16'(DIV);
        pulse(2); pulse(0); clks(8);
        send(8'hE7, 1'b1);
        chk("R2 divisor restored", rx_data, 8'hE7);
    endtask

    initial begin
        clks(4); rst_n = 1'b1; clks(2);
        test_reset_state();
        test_basic();
        test_glitch();
        test_ferr_overrun();
        test_disable();
        test_abort();
        test_div0();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule